// File: doc/BRIEF.md
# Block-Transfer Synchronous Serial Port

This block is a clocked synchronous serial port that moves a block of bytes between a built-in 32-byte buffer and the serial lines without help from the processor for each byte. Software first fills the buffer through a simple write port. It then sets the byte count and pulses start. The port shifts out each buffer byte and shifts in one byte from the partner at the same time. The received byte replaces the transmitted byte in the same buffer location. When the last byte is done, busy drops and a one-cycle completion pulse is raised.

The serial clock can come from either of two places. The block can generate it from the system clock, with a period of 8 system cycles. It can also take it from the pin: in that case it passes the pin clock through a synchroniser and detects its edges on the system clock. In the optional chip-select mode, the serial clock and data-out drivers are enabled only while the active-low select is asserted. The transfer waits while select is high between bytes. If select is released in the middle of a byte, the transfer is abandoned.

Top module: `atx_sio`

## Requirements
- R1: While idle, a write through the register port stores a byte at any of the 32 buffer locations. `reg_rdata_o` shows the byte at `reg_addr_i` combinationally.
- R2: Start while idle begins a transfer of exactly L bytes, where L is `len_i`, from 1 to 31, and a `len_i` of 0 means 32. `busy_o` is high from the cycle after start until the transfer ends. Without a start, the block stays idle.
- R3: Bytes go out most significant bit first, starting at buffer location 0. `so_o` takes each new bit at a falling SCK edge. `si_i` is sampled at each rising SCK edge.
- R4: After each byte, the received byte is written to the location of the byte just sent, and the pointer moves to the next location. Locations at index L and above are not changed.
- R5: In internal-clock mode (`ext_sck_i`=0), `sck_o` idles high, `sck_oe_o` is high, and one SCK period is 8 system-clock cycles.
- R6: In external-clock mode (`ext_sck_i`=1), the port is clocked by `sck_i`, with each SCK phase lasting at least 4 system cycles, and `sck_oe_o` is low.
- R7: `done_o` is a pulse exactly one cycle long. It comes in the first cycle with `busy_o` low after the last byte, once per completed transfer.
- R8: While busy, start and register-port writes are ignored. The running transfer and the buffer are unaffected.
- R9: In chip-select mode (`cs_mode_i`=1), `so_oe_o` and `sck_oe_o` are low while `cs_ni` is high. A high `cs_ni` between bytes pauses the transfer, and it resumes when `cs_ni` goes low.
- R10: In chip-select mode, `cs_ni` rising in the middle of a byte ends the transfer. In that case `busy_o` clears, `abort_o` is set, `done_o` is not raised, and the partial byte is not written. The next accepted start clears `abort_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Buffer write strobe |
| reg_addr_i | input | 5 | Buffer address for write and read |
| reg_wdata_i | input | 8 | Buffer write data |
| reg_rdata_o | output | 8 | Buffer read data at reg_addr_i |
| len_i | input | 5 | Byte count, 0 means 32 |
| start_i | input | 1 | Start request |
| ext_sck_i | input | 1 | 1 selects SCK from the pin |
| cs_mode_i | input | 1 | 1 enables chip-select gating |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| abort_o | output | 1 | Last transfer was abandoned mid-byte |
| sck_i | input | 1 | Serial clock from pin |
| sck_o | output | 1 | Generated serial clock |
| sck_oe_o | output | 1 | Serial clock driver enable |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Serial data out driver enable |
| si_i | input | 1 | Serial data in |
| cs_ni | input | 1 | Chip select, active low |

## Verification
The bench acts as the serial partner and targets several corner cases.

- A full 32-byte block, selected by a count of 0: a design that mishandles the zero code would stop early or never finish.
- A single-byte block: a design with an off-by-one in the count would move two bytes or raise no done.
- A start and a buffer write injected mid-transfer: a design that accepts them would restart from location 0 or corrupt a location that should be untouched.
- A chip-select pause exactly at a byte boundary: a design that does not pause cleanly would either abort or lose a bit.
- A chip-select release three bits into a byte: a design that aborts wrongly would write the partial byte, raise done, or keep the abort flag after the next start.

// File: rtl/atx_sio_pkg.sv
`timescale 1ns/1ps
package atx_sio_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } sck_evt_t;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_RUN  = 2'd1
  } xfer_st_e;
endpackage

// File: rtl/atx_sio_sync.sv
`timescale 1ns/1ps
module atx_sio_sync #(
  parameter int STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sck_i,
  input  logic                  si_i,
  input  logic                  cs_ni,
  output logic                  si_s_o,
  output logic                  cs_n_s_o,
  output atx_sio_pkg::sck_evt_t evt_o
);
  logic [STAGES-1:0] sck_q, si_q, cs_q;
  logic              sck_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q      <= '1;
      si_q       <= '0;
      cs_q       <= '1;
      sck_prev_q <= 1'b1;
    end else begin
      sck_q      <= {sck_q[STAGES-2:0], sck_i};
      si_q       <= {si_q[STAGES-2:0], si_i};
      cs_q       <= {cs_q[STAGES-2:0], cs_ni};
      sck_prev_q <= sck_q[STAGES-1];
    end
  end

  assign si_s_o     = si_q[STAGES-1];
  assign cs_n_s_o   = cs_q[STAGES-1];
  assign evt_o.rise = sck_q[STAGES-1] & ~sck_prev_q;
  assign evt_o.fall = ~sck_q[STAGES-1] & sck_prev_q;
endmodule

// File: rtl/atx_sio_clkgen.sv
`timescale 1ns/1ps
module atx_sio_clkgen #(
  parameter int DIV = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  output logic                  sck_o,
  output atx_sio_pkg::sck_evt_t evt_o
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q;
  logic          sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (!en_i) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else begin
      cnt_q <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + CW'(1);
      if (cnt_q == '0)         sck_q <= 1'b0;
      if (cnt_q == CW'(HALF))  sck_q <= 1'b1;
    end
  end

  assign sck_o      = sck_q;
  assign evt_o.fall = en_i & (cnt_q == '0);
  assign evt_o.rise = en_i & (cnt_q == CW'(HALF));
endmodule

// File: rtl/atx_sio_buf.sv
`timescale 1ns/1ps
module atx_sio_buf #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/atx_sio.sv
`timescale 1ns/1ps
module atx_sio #(
  parameter int DEPTH       = 32,
  parameter int DATA_W      = 8,
  parameter int SCK_DIV     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH),
  localparam int BW         = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [AW-1:0]     len_i,
  input  logic              start_i,
  input  logic              ext_sck_i,
  input  logic              cs_mode_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              abort_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic              si_i,
  input  logic              cs_ni
);
  import atx_sio_pkg::*;

  xfer_st_e          st_q;
  logic [AW-1:0]     ptr_q;
  logic [AW:0]       left_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
  logic              so_q, in_byte_q, done_q, err_q, cs_prev_q;

  logic              busy, si_s, cs_n_s, cs_ok_s, cs_rise, abort_hit;
  logic              gen_en, last_bit, byte_end;
  sck_evt_t          ext_evt, gen_evt, evt;
  logic              buf_we;
  logic [AW-1:0]     buf_waddr, rd_b_addr;
  logic [DATA_W-1:0] buf_wdata, rd_b_data, rx_byte;

  assign busy    = (st_q == XS_RUN);
  assign cs_ok_s = ~cs_mode_i | ~cs_n_s;
  assign cs_rise = cs_n_s & ~cs_prev_q;

  atx_sio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_i    (sck_i),
    .si_i     (si_i),
    .cs_ni    (cs_ni),
    .si_s_o   (si_s),
    .cs_n_s_o (cs_n_s),
    .evt_o    (ext_evt)
  );

  assign gen_en = busy & ~ext_sck_i & cs_ok_s;

  atx_sio_clkgen #(.DIV(SCK_DIV)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (gen_en),
    .sck_o  (sck_o),
    .evt_o  (gen_evt)
  );

  always_comb begin
    evt = ext_sck_i ? ext_evt : gen_evt;
    if (!(busy && cs_ok_s)) evt = '0;
  end

  assign abort_hit = busy & cs_mode_i & cs_rise & in_byte_q;
  assign last_bit  = (bit_q == BW'(DATA_W - 1));
  assign byte_end  = evt.rise & last_bit & ~abort_hit;
  assign rx_byte   = {rx_sh_q[DATA_W-2:0], si_s};

  // register port is locked out while a transfer owns the buffer
  assign buf_we    = busy ? byte_end : reg_we_i;
  assign buf_waddr = busy ? ptr_q : reg_addr_i;
  assign buf_wdata = busy ? rx_byte : reg_wdata_i;
  assign rd_b_addr = busy ? ptr_q + AW'(1) : '0;

  atx_sio_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_buf (
    .clk_i     (clk_i),
    .we_i      (buf_we),
    .waddr_i   (buf_waddr),
    .wdata_i   (buf_wdata),
    .raddr_a_i (reg_addr_i),
    .rdata_a_o (reg_rdata_o),
    .raddr_b_i (rd_b_addr),
    .rdata_b_o (rd_b_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= XS_IDLE;
      ptr_q     <= '0;
      left_q    <= '0;
      bit_q     <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      so_q      <= 1'b1;
      in_byte_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      cs_prev_q <= 1'b1;
    end else begin
      cs_prev_q <= cs_n_s;
      done_q    <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          st_q      <= XS_RUN;
          ptr_q     <= '0;
          left_q    <= (len_i == '0) ? (AW+1)'(DEPTH) : {1'b0, len_i};
          bit_q     <= '0;
          tx_sh_q   <= rd_b_data;
          in_byte_q <= 1'b0;
          err_q     <= 1'b0;
        end
      end else if (abort_hit) begin
        st_q      <= XS_IDLE;
        bit_q     <= '0;
        in_byte_q <= 1'b0;
        err_q     <= 1'b1;
      end else if (evt.fall) begin
        so_q      <= tx_sh_q[DATA_W-1];
        tx_sh_q   <= {tx_sh_q[DATA_W-2:0], 1'b0};
        in_byte_q <= 1'b1;
      end else if (evt.rise) begin
        rx_sh_q <= rx_byte;
        if (last_bit) begin
          bit_q     <= '0;
          in_byte_q <= 1'b0;
          ptr_q     <= ptr_q + AW'(1);
          left_q    <= left_q - (AW+1)'(1);
          tx_sh_q   <= rd_b_data;
          if (left_q == (AW+1)'(1)) begin
            st_q   <= XS_IDLE;
            done_q <= 1'b1;
          end
        end else begin
          bit_q <= bit_q + BW'(1);
        end
      end
    end
  end

  assign busy_o   = busy;
  assign done_o   = done_q;
  assign abort_o  = err_q;
  assign so_o     = so_q;
  assign so_oe_o  = ~cs_mode_i | ~cs_ni;
  assign sck_oe_o = ~ext_sck_i & (~cs_mode_i | ~cs_ni);
endmodule

// File: rtl/atx_sio_chk.sv
`timescale 1ns/1ps
module atx_sio_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic abort_o,
  input logic sck_o
);
  a_r2_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);

  a_r7_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_at_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r5_sck_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> sck_o);

  a_r10_abort_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> (!busy_o && !done_o));

  a_r10_abort_cleared_by_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(abort_o) |-> $past(start_i));
endmodule

bind atx_sio atx_sio_chk chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .abort_o (abort_o),
  .sck_o   (sck_o)
);

// File: tb/atx_sio_tb_top.sv
`timescale 1ns/1ps
module atx_sio_tb_top;
  localparam int DEPTH = 32;
  localparam int HPH   = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [4:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [4:0] len_i = '0;
  logic       start_i = 1'b0, ext_sck_i = 1'b0, cs_mode_i = 1'b0;
  logic       busy_o, done_o, abort_o;
  logic       sck_i = 1'b1, sck_o, sck_oe_o, so_o, so_oe_o;
  logic       si_i = 1'b0, cs_ni = 1'b1;

  always #4 clk = ~clk;

  atx_sio dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .len_i(len_i), .start_i(start_i),
    .ext_sck_i(ext_sck_i), .cs_mode_i(cs_mode_i),
    .busy_o(busy_o), .done_o(done_o), .abort_o(abort_o),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe_o),
    .so_o(so_o), .so_oe_o(so_oe_o), .si_i(si_i), .cs_ni(cs_ni)
  );

  int checks = 0, errors = 0;
  int cyc = 0, done_cnt = 0;
  int bit_total = 0, nfall = 0, first_fall = 0, period = 0;
  int poke_at = -1;
  logic poke_on = 1'b0;
  logic sck_prev = 1'b1;
  logic [7:0] exp_tx [DEPTH];
  logic [7:0] exp_rx [DEPTH];
  logic [7:0] so_cap [DEPTH];

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (done_o) done_cnt++;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = 5'(a); reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    reg_addr_i = 5'(a);
    #1 d = reg_rdata_o;
  endtask

  task automatic setup(input int seed);
    for (int j = 0; j < DEPTH; j++) begin
      exp_tx[j] = 8'(j * 29 + seed);
      exp_rx[j] = 8'(~(j * 13 + seed * 3));
      so_cap[j] = '0;
      wr(j, exp_tx[j]);
    end
    bit_total = 0; nfall = 0; period = 0; done_cnt = 0; sck_prev = 1'b1;
  endtask

  task automatic kick(input int len);
    len_i = 5'(len); start_i = 1'b1;
    tick();
    start_i = 1'b0;
  endtask

  task automatic serve_int(input int target);
    int guard = 0;
    while (bit_total < target && guard < 20000) begin
      tick(); guard++;
      if (poke_on) begin start_i = 1'b0; reg_we_i = 1'b0; poke_on = 1'b0; end
      if (sck_prev && !sck_o) begin
        si_i = exp_rx[bit_total / 8][7 - (bit_total % 8)];
        nfall++;
        if (nfall == 1) first_fall = cyc;
        if (nfall == 2) period = cyc - first_fall;
      end else if (!sck_prev && sck_o) begin
        so_cap[bit_total / 8] = {so_cap[bit_total / 8][6:0], so_o};
        bit_total++;
        if (bit_total == poke_at) begin
          start_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 5'(DEPTH - 1);
          reg_wdata_i = 8'h5A; poke_on = 1'b1;
        end
      end
      sck_prev = sck_o;
    end
  endtask

  task automatic serve_ext(input int target);
    while (bit_total < target) begin
      sck_i = 1'b0;
      si_i = exp_rx[bit_total / 8][7 - (bit_total % 8)];
      repeat (HPH) tick();
      so_cap[bit_total / 8] = {so_cap[bit_total / 8][6:0], so_o};
      sck_i = 1'b1;
      bit_total++;
      repeat (HPH) tick();
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40; i++) begin
      tick();
      if (!busy_o) break;
    end
    repeat (2) tick();
  endtask

  task automatic check_so(input string req, input int n);
    for (int j = 0; j < n; j++) chk_eq(req, $sformatf("so byte %0d", j), so_cap[j], exp_tx[j]);
  endtask

  task automatic check_buf(input string req, input int n);
    logic [7:0] d;
    for (int j = 0; j < DEPTH; j++) begin
      rd(j, d);
      chk_eq(req, $sformatf("buf[%0d]", j), d, (j < n) ? exp_rx[j] : exp_tx[j]);
    end
  endtask

  task automatic t_reset();
    chk_eq("R2", "busy after reset", busy_o, 0);
    chk_eq("R7", "done after reset", done_o, 0);
    chk_eq("R10", "abort after reset", abort_o, 0);
    chk_eq("R5", "sck idle level", sck_o, 1);
    chk_eq("R5", "sck_oe internal", sck_oe_o, 1);
  endtask

  task automatic t_buffer();
    logic [7:0] d;
    for (int j = 0; j < DEPTH; j++) wr(j, 8'(j ^ 8'hA5));
    for (int j = 0; j < DEPTH; j++) begin
      rd(j, d);
      chk_eq("R1", $sformatf("readback %0d", j), d, 8'(j ^ 8'hA5));
    end
  endtask

  task automatic t_int(input int len, input int seed, input int poke);
    int n = (len == 0) ? DEPTH : len;
    ext_sck_i = 1'b0; cs_mode_i = 1'b0;
    setup(seed);
    poke_at = poke;
    kick(len);
    chk_eq("R2", "busy after start", busy_o, 1);
    serve_int(n * 8);
    wait_idle();
    poke_at = -1;
    chk_eq("R2", "busy after block", busy_o, 0);
    chk_eq("R2", "bits moved", bit_total, n * 8);
    chk_eq("R7", "done pulses", done_cnt, 1);
    chk_eq("R5", "sck period", period, 8);
    check_so("R3", n);
    check_buf((poke >= 0) ? "R8" : "R4", n);
  endtask

  task automatic t_ext();
    ext_sck_i = 1'b1; cs_mode_i = 1'b0;
    setup(7);
    kick(3);
    chk_eq("R6", "sck_oe external", sck_oe_o, 0);
    serve_ext(24);
    wait_idle();
    chk_eq("R6", "done pulses", done_cnt, 1);
    chk_eq("R6", "busy end", busy_o, 0);
    check_so("R6", 3);
    check_buf("R6", 3);
    ext_sck_i = 1'b0;
  endtask

  task automatic t_cs_pause();
    ext_sck_i = 1'b0; cs_mode_i = 1'b1; cs_ni = 1'b1;
    setup(41);
    kick(2);
    repeat (16) tick();
    chk_eq("R9", "busy while deselected", busy_o, 1);
    chk_eq("R9", "no clock while deselected", sck_o, 1);
    chk_eq("R9", "so_oe deselected", so_oe_o, 0);
    chk_eq("R9", "sck_oe deselected", sck_oe_o, 0);
    cs_ni = 1'b0;
    tick();
    chk_eq("R9", "so_oe selected", so_oe_o, 1);
    chk_eq("R9", "sck_oe selected", sck_oe_o, 1);
    serve_int(8);
    cs_ni = 1'b1;
    repeat (20) tick();
    chk_eq("R9", "busy in pause", busy_o, 1);
    chk_eq("R9", "no abort at boundary", abort_o, 0);
    chk_eq("R9", "no done in pause", done_cnt, 0);
    cs_ni = 1'b0;
    serve_int(16);
    wait_idle();
    chk_eq("R9", "done after resume", done_cnt, 1);
    check_so("R9", 2);
    check_buf("R9", 2);
    cs_ni = 1'b1; cs_mode_i = 1'b0;
  endtask

  task automatic t_abort();
    logic [7:0] d;
    ext_sck_i = 1'b0; cs_mode_i = 1'b1; cs_ni = 1'b0;
    setup(90);
    kick(3);
    serve_int(11);
    cs_ni = 1'b1;
    repeat (12) tick();
    chk_eq("R10", "busy after abort", busy_o, 0);
    chk_eq("R10", "abort flag", abort_o, 1);
    chk_eq("R10", "no done on abort", done_cnt, 0);
    rd(0, d); chk_eq("R10", "buf0 kept", d, exp_rx[0]);
    rd(1, d); chk_eq("R10", "partial discarded", d, exp_tx[1]);
    rd(2, d); chk_eq("R10", "buf2 untouched", d, exp_tx[2]);
    cs_mode_i = 1'b0;
    setup(3);
    kick(1);
    chk_eq("R10", "abort cleared by start", abort_o, 0);
    serve_int(8);
    wait_idle();
    chk_eq("R10", "done after recovery", done_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_buffer();
    t_int(5, 17, 12);
    t_int(0, 55, -1);
    t_int(1, 200, -1);
    t_ext();
    t_cs_pause();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R2: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule